// File: doc/BRIEF.md
# UDP Receive Word Buffer With Acknowledge Read

This block sits between a packet parser and the application. It stores received UDP payload words, each 64 bits wide, together with per-word flags and the sender's address. It shows the oldest stored word on its read port until the application acknowledges it. The parser supplies a write stream of data, valid, last, bad-CRC, source IP and source port. The application sees the current word, the source IP and UDP port of the packet it belongs to, an end-of-frame marker, and a CRC-error flag and an overrun flag. Both flags only carry meaning on the last word.

Received frames may be of any length, so the buffer detects overrun from its own occupancy. One slot is always kept free. A data word that arrives when only that slot is left is dropped, along with everything after it. A single terminating entry, flagged end-of-frame and overrun, then goes into the free slot. The write side then discards all input until the application strobes the overrun acknowledge. If that strobe comes while a packet is still arriving, the rest of that packet is skipped and storing resumes at the next packet start. The overrun output may be wired straight back to the overrun acknowledge input.

Top module: `udp_rx_ack_buffer`

## Requirements
- R1: After a cycle with `rst` high, `rx_valid`, `rx_end_of_frame`, `rx_bad_frame` and `rx_overrun` are low and the buffer is empty.
- R2: `rx_valid` is high whenever at least one entry is stored, and a written word is visible on `rx_data` one clock edge after it is written. Entries are read in write order.
- R3: A cycle with `rx_valid` and `rx_ack` high removes the current entry, and the next entry appears after that edge. Without any acknowledge, all read outputs hold their values.
- R4: `rx_ack` while `rx_valid` is low has no effect: a packet written afterwards is read back complete from its first word.
- R5: `rx_end_of_frame` is high exactly while the entry written with `wr_last` high (or an overrun entry) is presented.
- R6: `rx_bad_frame` is high only together with `rx_end_of_frame`, and it equals `wr_crc_bad` as sampled with the packet's last word. On earlier words it stays low.
- R7: `rx_source_ip` and `rx_source_port` show the values sampled with the first word of the packet, for every word of that packet, including its overrun entry.
- R8: With 2^ADDR_W slots, a data word arriving while at least 2^ADDR_W−1 entries are stored starts an overrun. That word and the rest of its packet are dropped, and exactly one entry is stored after the accepted words, with data 0 and end-of-frame and overrun high.
- R9: After an overrun, every write is discarded until a cycle with `rx_overrun_ack` high once the terminating entry is stored. If the write side is mid-packet at that point, the rest of that packet is also discarded, and the next packet is stored normally.
- R10: `rx_overrun_ack` while the overrun entry is presented removes that entry as `rx_ack` would. Tying `rx_overrun` to `rx_overrun_ack` therefore clears the overrun and the block accepts new packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word strobe from the parser |
| wr_data | input | 64 | Payload word |
| wr_last | input | 1 | Marks the last word of a packet |
| wr_crc_bad | input | 1 | CRC error on the packet, meaningful with wr_last |
| wr_src_ip | input | 32 | Sender IP, sampled on the first word |
| wr_src_port | input | 16 | Sender UDP port, sampled on the first word |
| rx_ack | input | 1 | Consumes the presented word |
| rx_overrun_ack | input | 1 | Releases the overrun block; also consumes the overrun entry |
| rx_valid | output | 1 | Buffer holds at least one entry |
| rx_data | output | 64 | Current word |
| rx_end_of_frame | output | 1 | Current word ends a packet |
| rx_bad_frame | output | 1 | CRC error, qualified by end-of-frame |
| rx_overrun | output | 1 | Overrun, qualified by end-of-frame |
| rx_source_ip | output | 32 | Sender IP of the current packet |
| rx_source_port | output | 16 | Sender UDP port of the current packet |

## Verification
The assertions assume that reset is applied before the first meaningful cycle. They also assume the parser delivers well-formed packets, with each packet ending in a word marked last. They do not assume the acknowledge inputs are quiet while the buffer is empty or not blocked, and they check that such strobes do no harm. The stimulus drives only whole, well-formed packets. It changes inputs on the falling clock edge and pulses each acknowledge for one cycle, except where the overrun output is looped back to its acknowledge.

// File: rtl/udp_rx_ack_buffer.sv
module udp_rx_ack_buffer #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              wr_crc_bad,
  input  logic [31:0]       wr_src_ip,
  input  logic [15:0]       wr_src_port,
  input  logic              rx_ack,
  input  logic              rx_overrun_ack,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_end_of_frame,
  output logic              rx_bad_frame,
  output logic              rx_overrun,
  output logic [31:0]       rx_source_ip,
  output logic [15:0]       rx_source_port
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = ADDR_W + 1;
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] RES_LVL = CW'(DEPTH - 1);
  localparam logic [1:0] ST_RUN = 2'd0, ST_BLOCK = 2'd1, ST_SKIP = 2'd2;

  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [2:0]        mem_flag [DEPTH];
  logic [47:0]       mem_src  [DEPTH];

  logic [ADDR_W-1:0] wp, rp;
  logic [CW-1:0]     count;
  logic [1:0]        st_q;
  logic              term_pend, in_pkt;
  logic [31:0]       ip_q;
  logic [15:0]       port_q;

  wire [31:0] cur_ip   = in_pkt ? ip_q : wr_src_ip;
  wire [15:0] cur_port = in_pkt ? port_q : wr_src_port;

  wire data_wr = (st_q == ST_RUN) && wr_valid && (count < RES_LVL);
  wire ovf     = (st_q == ST_RUN) && wr_valid && (count >= RES_LVL);
  wire term_wr = term_pend && (count < FULL_LVL);
  wire wr_en   = data_wr || term_wr;

  wire [2:0] head = mem_flag[rp];
  wire pop = rx_valid && (rx_ack || (rx_overrun_ack && head[2]));

  assign rx_valid        = count != '0;
  assign rx_data         = mem_data[rp];
  assign rx_end_of_frame = rx_valid && head[0];
  assign rx_bad_frame    = rx_valid && head[0] && head[1];
  assign rx_overrun      = rx_valid && head[2];
  assign rx_source_ip    = mem_src[rp][47:16];
  assign rx_source_port  = mem_src[rp][15:0];

  always_ff @(posedge clk) begin
    if (data_wr) begin
      mem_data[wp] <= wr_data;
      mem_flag[wp] <= {1'b0, wr_crc_bad, wr_last};
      mem_src[wp]  <= {cur_ip, cur_port};
    end else if (term_wr) begin
      mem_data[wp] <= '0;
      mem_flag[wp] <= 3'b101;
      mem_src[wp]  <= {ip_q, port_q};
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && !in_pkt) begin
      ip_q   <= wr_src_ip;
      port_q <= wr_src_port;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      count     <= '0;
      st_q      <= ST_RUN;
      term_pend <= 1'b0;
      in_pkt    <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (pop)   rp <= rp + 1'b1;
      count <= count + CW'(wr_en) - CW'(pop);
      if (wr_valid) in_pkt <= !wr_last;
      term_pend <= ovf || (term_pend && !term_wr);
      case (st_q)
        ST_RUN:   if (ovf) st_q <= ST_BLOCK;
        ST_BLOCK: if (rx_overrun_ack && !term_pend)
                    st_q <= (wr_valid ? !wr_last : in_pkt) ? ST_SKIP : ST_RUN;
        ST_SKIP:  if (wr_valid && wr_last) st_q <= ST_RUN;
        default:  st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/udp_rx_ack_buffer_chk.sv
module udp_rx_ack_buffer_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_ack,
  input logic              rx_overrun_ack,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_end_of_frame,
  input logic              rx_bad_frame,
  input logic              rx_overrun,
  input logic [ADDR_W:0]   occ,
  input logic [1:0]        st,
  input logic              wr_en
);
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(1 << ADDR_W);

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_end_of_frame && !rx_overrun));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ack && !rx_overrun_ack) |=> (rx_valid && $stable(rx_data) && $stable(rx_end_of_frame)));

  p_empty_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !wr_en) |=> !rx_valid);

  p_bad_needs_eof_r6: assert property (@(posedge clk) disable iff (rst)
    rx_bad_frame |-> rx_end_of_frame);

  p_ovr_entry_r8: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> (rx_end_of_frame && rx_data == '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_LVL);

  p_block_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && !rx_overrun_ack) |=> st == 2'd1);
endmodule

bind udp_rx_ack_buffer udp_rx_ack_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rx_ack(rx_ack), .rx_overrun_ack(rx_overrun_ack),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_end_of_frame(rx_end_of_frame),
  .rx_bad_frame(rx_bad_frame), .rx_overrun(rx_overrun), .occ(count),
  .st(st_q), .wr_en(wr_en)
);

// File: tb/test_udp_rx_ack_buffer.sv
`timescale 1ns/1ps
module test_udp_rx_ack_buffer;
  localparam int AW = 3;
  localparam int KEEP = (1 << AW) - 1;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_last = 0, wr_crc_bad = 0;
  logic [63:0] wr_data = '0;
  logic [31:0] wr_src_ip = '0;
  logic [15:0] wr_src_port = '0;
  logic rx_ack = 0, ack_drv = 0, tie = 0;
  logic rx_valid, rx_end_of_frame, rx_bad_frame, rx_overrun;
  logic [63:0] rx_data;
  logic [31:0] rx_source_ip;
  logic [15:0] rx_source_port;
  wire ovr_ack = tie ? rx_overrun : ack_drv;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  udp_rx_ack_buffer #(.ADDR_W(AW)) i_udp_rx_ack_buffer (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_crc_bad(wr_crc_bad), .wr_src_ip(wr_src_ip), .wr_src_port(wr_src_port),
    .rx_ack(rx_ack), .rx_overrun_ack(ovr_ack), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_end_of_frame(rx_end_of_frame), .rx_bad_frame(rx_bad_frame), .rx_overrun(rx_overrun),
    .rx_source_ip(rx_source_ip), .rx_source_port(rx_source_port));

  function automatic logic [63:0] wd(int p, int i);
    return {32'hC0DE0000 + 32'(p), 32'(i * 7 + 3)};
  endfunction
  function automatic logic [31:0] ipof(int p); return 32'h0A000000 + 32'(p); endfunction
  function automatic logic [15:0] portof(int p); return 16'(49152 + p); endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int p, int i, bit last);
    @(negedge clk);
    wr_valid = 1; wr_data = wd(p, i); wr_last = last; wr_crc_bad = p[0];
    wr_src_ip = (i == 0) ? ipof(p) : ~ipof(p);
    wr_src_port = (i == 0) ? portof(p) : ~portof(p);
  endtask

  task automatic idle();
    @(negedge clk); wr_valid = 0; wr_last = 0;
  endtask

  task automatic send(int p, int len);
    for (int i = 0; i < len; i++) put(p, i, i == len - 1);
    idle();
  endtask

  task automatic pop_check(logic [63:0] d, bit eof, bit bad, bit ovr, int p, string req);
    chk(rx_valid == 1, {req, " valid"}, 64'(rx_valid), 1);
    chk(rx_data == d, {req, " data"}, rx_data, d);
    chk(rx_end_of_frame == eof, {req, " R5 eof"}, 64'(rx_end_of_frame), 64'(eof));
    chk(rx_bad_frame == bad, {req, " R6 bad"}, 64'(rx_bad_frame), 64'(bad));
    chk(rx_overrun == ovr, {req, " R8 ovr"}, 64'(rx_overrun), 64'(ovr));
    chk(rx_source_ip == ipof(p) && rx_source_port == portof(p), {req, " R7 src"},
        {rx_source_ip, 16'h0, rx_source_port}, {ipof(p), 16'h0, portof(p)});
    rx_ack = 1;
    @(negedge clk);
    rx_ack = 0;
  endtask

  task automatic read_pkt(int p, int len, string req);
    for (int i = 0; i < len; i++)
      pop_check(wd(p, i), i == len - 1, (i == len - 1) && p[0], 0, p, req);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(!rx_valid && !rx_end_of_frame && !rx_bad_frame && !rx_overrun, "R1 reset", 64'(rx_valid), 0);
    // R4: acknowledges into an empty buffer
    rx_ack = 1; @(negedge clk); rx_ack = 0;
    chk(!rx_valid, "R4 empty ack", 64'(rx_valid), 0);
    // R2 R3 R5 R6 R7: sweep lengths that fit
    for (int len = 1; len <= KEEP; len++) begin
      send(len, len);
      read_pkt(len, len, "R2 sweep");
      chk(!rx_valid, "R3 drained", 64'(rx_valid), 0);
    end
    // R3 hold
    send(40, 2);
    repeat (3) @(negedge clk);
    chk(rx_data == wd(40, 0), "R3 hold", rx_data, wd(40, 0));
    read_pkt(40, 2, "R3 after hold");
    // R2 two packets back to back
    send(41, 2); send(42, 3);
    read_pkt(41, 2, "R2 order a"); read_pkt(42, 3, "R2 order b");
    // R4 then full read
    rx_ack = 1; @(negedge clk); rx_ack = 0;
    send(43, 3);
    read_pkt(43, 3, "R4 after empty ack");
    // R8 R10: overrun with overrun tied back to its acknowledge
    tie = 1;
    send(20, 12);
    read_pkt_partial: for (int i = 0; i < KEEP; i++)
      pop_check(wd(20, i), 0, 0, 0, 20, "R8 kept words");
    chk(rx_overrun && rx_end_of_frame && rx_data == 0, "R8 terminator", 64'(rx_overrun), 1);
    chk(rx_source_ip == ipof(20), "R7 terminator src", 64'(rx_source_ip), 64'(ipof(20)));
    @(negedge clk);
    chk(!rx_valid, "R10 single terminator", 64'(rx_valid), 0);
    tie = 0;
    send(21, 3);
    read_pkt(21, 3, "R10 resumed");
    // R9: blocked drops, then skip of partial packet
    send(30, 9);
    send(31, 2);
    for (int i = 0; i < KEEP; i++) pop_check(wd(30, i), 0, 0, 0, 30, "R8 kept words 2");
    pop_check(64'h0, 1, 0, 1, 30, "R8 terminator 2");
    chk(!rx_valid, "R9 blocked drop", 64'(rx_valid), 0);
    put(32, 0, 0); idle();
    @(negedge clk); ack_drv = 1; @(negedge clk); ack_drv = 0;
    put(32, 1, 1); idle();
    chk(!rx_valid, "R9 skip rest", 64'(rx_valid), 0);
    send(33, 2);
    read_pkt(33, 2, "R9 resume");
    chk(!rx_valid, "R9 drained", 64'(rx_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule